// File: doc/BRIEF.md
# Prescaled watchdog timer

This block is a watchdog timer that a processor reaches through a small register bus: an address, a write strobe, write data and read data that is always valid. The input clock passes through two cascaded stages, a programmable 8-bit prescaler and a fixed power-of-two divider, to make a slow tick. Each tick lowers a 16-bit live counter by one. When the counter runs out, the block emits a one-clock interrupt pulse, a one-clock system reset request, or both, depending on two independent enable bits. The counter then reloads from a separate reload register and starts over.

Software keeps the system alive by writing the live count register before it runs out. To stop the watchdog it clears the run bit. Clearing the run bit also clears the partial progress of both divider stages, so a later restart always begins with a full tick period. A forced reset is available: load a short count and enable the reset output.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0, the reload and live count registers both read 0x8000, and `irq_pulse` and `rst_req` are low.
- R2: The control register is at byte offset 0x0, the reload register at 0x4 and the live count at 0x8. In control, bit 0 is reset-enable, bit 2 is interrupt-enable, bits [4:3] are the divider select, bit 5 is run, and bits [15:8] are the prescaler value P. All other control bits read 0. The reload and count registers hold 16 bits and read with the upper bits 0. Any other address reads 0 and ignores writes.
- R3: While run is 1, a tick occurs every (P+1)·D input clocks, where D is 16, 32, 64 or 128 for select values 0, 1, 2 and 3. Each tick lowers the live count by one.
- R4: If the live count is N ≥ 1 when run is set, the first expiry output rises exactly N·(P+1)·D clocks after the clock edge that writes run. At that expiry the live count takes the reload value.
- R5: At expiry, `irq_pulse` is high for exactly one clock if interrupt-enable is 1, and stays low if it is 0.
- R6: At expiry, `rst_req` is high for exactly one clock if reset-enable is 1, and stays low if it is 0. This does not depend on interrupt-enable.
- R7: A write to the live count register loads that value into the counter at once, and the write wins over a tick in the same cycle. A write to the reload register leaves the live count unchanged.
- R8: While run is 0, the live count holds its value and no output is asserted. The prescaler and divider progress is cleared, so after run is set again the next expiry comes a full N·(P+1)·D clocks later.
- R9: The forced-reset sequence sets control to 0, writes 0x80 to the count and then to the reload register, and writes control 0x2021 (P=0x20, divide by 16, run, reset-enable). It raises `rst_req` 33·16·128 = 67584 clocks after the final control write.
- R10: A live count of 0 expires on the next tick, in the same way as a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | One-clock interrupt pulse at expiry |
| rst_req | output | 1 | One-clock system reset request at expiry |

## Verification
The assertions assume the bus inputs are always known and that each high cycle of `bus_we` is exactly one write to the address present in that cycle. They also assume a count write is taken as the full 16-bit value, so a reload, a decrement and a service load can each be predicted from the previous cycle alone. The stimulus changes the bus only on falling clock edges and holds the write strobe for exactly one rising edge. It uses only the three defined offsets for writes, and for reads also one unmapped offset. Writes to divider or prescaler fields are made only from a stopped state or at a point where a half-finished tick does not matter to the expected timing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PRE_W         = 8;
    localparam int SEL_W         = 2;
    localparam int DIV_BASE_LOG2 = 4;

    localparam logic [3:0] OFS_CTRL   = 4'h0;
    localparam logic [3:0] OFS_RELOAD = 4'h4;
    localparam logic [3:0] OFS_COUNT  = 4'h8;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic [1:0]       rsv_hi;
        logic             run;
        logic [SEL_W-1:0] div_sel;
        logic             irq_en;
        logic             rsv_lo;
        logic             rst_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [CNT_W-1:0]     count_val,
    output wdt_pkg::ctrl_t       ctrl,
    output logic [CNT_W-1:0]     reload_val,
    output logic                 cnt_wr,
    output logic [CNT_W-1:0]     cnt_wr_val,
    output logic [DATA_W-1:0]    bus_rdata
);
    import wdt_pkg::*;

    localparam logic [CNT_W-1:0] RST_CNT = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } reg_st_t;

    reg_st_t q, d;

    logic hit_ctrl, hit_reload, hit_count;
    logic unused_wdata_hi;

    assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
    assign hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    always_comb begin
        d = q;
        if (bus_we && hit_ctrl) begin
            d.ctrl        = ctrl_t'(bus_wdata[CTRL_W-1:0]);
            d.ctrl.rsv_hi = '0;
            d.ctrl.rsv_lo = 1'b0;
        end
        if (bus_we && hit_reload) begin
            d.reload = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: '0, reload: RST_CNT};
        end else begin
            q <= d;
        end
    end

    assign ctrl       = q.ctrl;
    assign reload_val = q.reload;
    assign cnt_wr     = bus_we && hit_count;
    assign cnt_wr_val = bus_wdata[CNT_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[CTRL_W-1:0] = q.ctrl;
        end else if (hit_reload) begin
            bus_rdata[CNT_W-1:0] = q.reload;
        end else if (hit_count) begin
            bus_rdata[CNT_W-1:0] = count_val;
        end
    end

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int PRE_W         = wdt_pkg::PRE_W,
    parameter int SEL_W         = wdt_pkg::SEL_W,
    parameter int DIV_BASE_LOG2 = wdt_pkg::DIV_BASE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int N_SEL  = 1 << SEL_W;
    localparam int DIVC_W = DIV_BASE_LOG2 + N_SEL - 1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre_cnt;
        logic [DIVC_W-1:0] div_cnt;
    } tick_st_t;

    tick_st_t q, d;

    logic [DIVC_W-1:0] lim_tab [N_SEL];
    logic [DIVC_W-1:0] div_lim;
    logic              pre_hit;
    logic              div_hit;

    for (genvar gi = 0; gi < N_SEL; gi++) begin : g_lim
        assign lim_tab[gi] = DIVC_W'((1 << (DIV_BASE_LOG2 + gi)) - 1);
    end

    assign div_lim = lim_tab[div_sel];
    assign pre_hit = run && (q.pre_cnt >= prescale);
    assign div_hit = (q.div_cnt >= div_lim);
    assign tick    = pre_hit && div_hit;

    always_comb begin
        d = q;
        if (!run) begin
            d = '0;
        end else if (pre_hit) begin
            d.pre_cnt = '0;
            d.div_cnt = div_hit ? '0 : q.div_cnt + DIVC_W'(1);
        end else begin
            d.pre_cnt = q.pre_cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             irq_en,
    input  logic             rst_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_val,
    output logic             irq_pulse,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] RST_CNT = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } cnt_st_t;

    cnt_st_t q, d;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        d.rst = 1'b0;
        if (load_en) begin
            d.cnt = load_val;
        end else if (tick) begin
            if (q.cnt <= CNT_W'(1)) begin
                d.cnt = reload_val;
                d.irq = irq_en;
                d.rst = rst_en;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: RST_CNT, irq: 1'b0, rst: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign count_val = q.cnt;
    assign irq_pulse = q.irq;
    assign rst_req   = q.rst;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse,
    output logic              rst_req
);
    import wdt_pkg::*;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count_val;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wr_val;
    logic             tick;
    logic             run_en;
    logic             irq_en;
    logic             rst_en;

    assign run_en = ctrl.run;
    assign irq_en = ctrl.irq_en;
    assign rst_en = ctrl.rst_en;

    wdt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .count_val  (count_val),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .cnt_wr     (cnt_wr),
        .cnt_wr_val (cnt_wr_val),
        .bus_rdata  (bus_rdata)
    );

    wdt_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .prescale (ctrl.prescale),
        .div_sel  (ctrl.div_sel),
        .tick     (tick)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .irq_en     (irq_en),
        .rst_en     (rst_en),
        .load_en    (cnt_wr),
        .load_val   (cnt_wr_val),
        .reload_val (reload_val),
        .count_val  (count_val),
        .irq_pulse  (irq_pulse),
        .rst_req    (rst_req)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             irq_en,
    input logic             rst_en,
    input logic             tick,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wr_val,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] reload_val,
    input logic             irq_pulse,
    input logic             rst_req
);

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !tick); // R8

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> $stable(count_val)); // R8

    AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count_val > CNT_W'(1)) |=> (count_val == $past(count_val) - CNT_W'(1))); // R3

    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count_val <= CNT_W'(1)) |=> (count_val == $past(reload_val))); // R4

    AST_IRQ_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count_val <= CNT_W'(1)) |=> (irq_pulse == $past(irq_en))); // R5

    AST_RST_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count_val <= CNT_W'(1)) |=> (rst_req == $past(rst_en))); // R6

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R5

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6

    AST_SERVICE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_val == $past(cnt_wr_val))); // R7

    AST_SERVICE_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (!irq_pulse && !rst_req)); // R7

endmodule

bind wdog_timer wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .irq_en     (irq_en),
    .rst_en     (rst_en),
    .tick       (tick),
    .cnt_wr     (cnt_wr),
    .cnt_wr_val (cnt_wr_val),
    .count_val  (count_val),
    .reload_val (reload_val),
    .irq_pulse  (irq_pulse),
    .rst_req    (rst_req)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_RLD  = 4'h4;
    localparam logic [3:0] A_CNT  = 4'h8;
    localparam logic [3:0] A_NONE = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wdog_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse),
        .rst_req   (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Returns on the falling edge of the first cycle that sees the new value.
    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic watch(input int span, output int f_irq, output int f_rst,
                         output int c_irq, output int c_rst);
        f_irq = -1; f_rst = -1; c_irq = 0; c_rst = 0;
        for (int c = 0; c < span; c++) begin
            if (irq_pulse) begin c_irq++; if (f_irq < 0) f_irq = c; end
            if (rst_req)   begin c_rst++; if (f_rst < 0) f_rst = c; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
        rd(A_RLD, v);  chk("R1 reload reset", v, 32'h8000);
        rd(A_CNT, v);  chk("R1 count reset", v, 32'h8000);
        chk("R1 outputs low", {30'b0, irq_pulse, rst_req}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R2 ctrl field mask", v, 32'h0000_FF3D);
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'h1234_ABCD);
        rd(A_RLD, v);  chk("R2 reload 16-bit", v, 32'h0000_ABCD);
        wr(A_NONE, 32'hFFFF_FFFF);
        rd(A_NONE, v); chk("R2 unmapped reads 0", v, 32'h0);
        rd(A_CTRL, v); chk("R2 unmapped write ignored", v, 32'h0);
    endtask

    task automatic t_tick();
        logic [31:0] v;
        wr(A_CNT, 32'd10);
        wr(A_RLD, 32'd50);
        wr(A_CTRL, 32'h0000_0120);          // P=1, D=16, run
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R3 before first tick", v, 32'd10);
        repeat (35) @(negedge clk);
        rd(A_CNT, v); chk("R3 after one tick", v, 32'd9);
        repeat (60) @(negedge clk);
        rd(A_CNT, v); chk("R3 after three ticks", v, 32'd7);
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd20);
        wr(A_CTRL, 32'h0000_0030);          // P=0, D=64, run
        repeat (63) @(negedge clk);
        rd(A_CNT, v); chk("R3 div64 last cycle before tick", v, 32'd20);
        @(negedge clk);
        rd(A_CNT, v); chk("R3 div64 after tick", v, 32'd19);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_expiry();
        int fi, fr, ci, cr;
        logic [31:0] v;
        wr(A_CNT, 32'd3);
        wr(A_RLD, 32'd5);
        wr(A_CTRL, 32'h0000_022D);          // P=2, D=32, run, irq, rst
        watch(300, fi, fr, ci, cr);
        chk("R4 expiry cycle irq", fi, 288);
        chk("R4 expiry cycle rst", fr, 288);
        chk("R5 single irq pulse", ci, 1);
        chk("R6 single rst pulse", cr, 1);
        rd(A_CNT, v); chk("R4 reload after expiry", v, 32'd5);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_irq_only();
        int fi, fr, ci, cr;
        wr(A_CNT, 32'd2);
        wr(A_RLD, 32'd2);
        wr(A_CTRL, 32'h0000_0024);          // run, irq only
        watch(40, fi, fr, ci, cr);
        chk("R5 irq at expiry", fi, 32);
        chk("R5 irq one pulse", ci, 1);
        chk("R6 rst disabled stays low", cr, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_rst_only();
        int fi, fr, ci, cr;
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h0000_0021);          // run, rst only
        watch(40, fi, fr, ci, cr);
        chk("R6 rst at expiry", fr, 32);
        chk("R5 irq disabled stays low", ci, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_service();
        int fi, fr, ci, cr;
        int tot = 0;
        logic [31:0] v;
        wr(A_CNT, 32'd4);
        wr(A_CTRL, 32'h0000_0025);          // run, irq, rst; 64-clock life
        for (int k = 0; k < 5; k++) begin
            watch(40, fi, fr, ci, cr);
            tot += ci + cr;
            wr(A_CNT, 32'd4);
        end
        chk("R7 serviced watchdog never fires", tot, 0);
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd7);
        rd(A_CNT, v); chk("R7 count write loads", v, 32'd7);
        wr(A_RLD, 32'h33);
        rd(A_CNT, v); chk("R7 reload write leaves count", v, 32'd7);
    endtask

    task automatic t_stop();
        int fi, fr, ci, cr;
        logic [31:0] v;
        wr(A_CNT, 32'd3);
        wr(A_RLD, 32'd3);
        wr(A_CTRL, 32'h0000_0025);
        watch(10, fi, fr, ci, cr);
        wr(A_CTRL, 32'h0000_0004);          // run and rst-enable off
        watch(200, fi, fr, ci, cr);
        chk("R8 no outputs while stopped", ci + cr, 0);
        rd(A_CNT, v); chk("R8 count holds while stopped", v, 32'd3);
        wr(A_CTRL, 32'h0000_0025);
        watch(60, fi, fr, ci, cr);
        chk("R8 full period after restart", fr, 48);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_zero();
        int fi, fr, ci, cr;
        wr(A_CNT, 32'd0);
        wr(A_RLD, 32'd2);
        wr(A_CTRL, 32'h0000_0021);
        watch(20, fi, fr, ci, cr);
        chk("R10 zero count expires on first tick", fr, 16);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_forced();
        int fi, fr, ci, cr;
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h80);
        wr(A_RLD, 32'h80);
        wr(A_CTRL, 32'h0000_2021);
        watch(67600, fi, fr, ci, cr);
        chk("R9 forced reset timing", fr, 67584);
        chk("R9 forced reset no irq", ci, 0);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_tick();
        t_expiry();
        t_irq_only();
        t_rst_only();
        t_service();
        t_stop();
        t_zero();
        t_forced();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule